// File: doc/BRIEF.md
# Byte-Stream to GMII Frame Transmitter

This block turns packets arriving on an 8-bit valid/ready stream with a last flag and a bad-frame flag into transmit signals for a gigabit media-independent interface. The signals are an 8-bit data bus, a transmit-enable line and a transmit-error line. In front of every packet it emits a seven-byte preamble and a start delimiter. It pads short payloads with zeros up to 60 bytes, appends a 32-bit frame check sequence, and keeps a configurable idle gap between packets.

The block can abort a packet. If the source flags the packet as bad on its final beat, or stops supplying data after the packet has started, the block marks the packet's final transfer with the error line. The packets before and after an aborted one are sent intact.

A select input switches the output to nibble-wide MII operation. A clock-enable input stalls the whole block, so one clock can serve several line rates.

Top module: `gmii_frame_tx`

## Requirements
- R1: While reset is high and on the first cycle after it, gmiiTxd is 0, gmiiTxEn is 0, gmiiTxEr is 0 and sTready is 0.
- R2: Every packet starts with seven bytes of 0x55, followed by one byte of 0xD5, followed by the payload bytes in their input order.
- R3: A good packet ends with four check bytes, least significant byte first. The check value is the reflected CRC-32 (generator 0x04C11DB7, start value 0xFFFFFFFF, result inverted) over the payload and any padding. The check bytes directly follow the last payload or pad byte.
- R4: A payload shorter than 60 bytes is followed by 0x00 bytes until 60 bytes have been sent, and the padding is included in the check value. A payload of 60 bytes or more gets no padding.
- R5: If sTuser is high on the beat that carries sTlast, that byte is sent with gmiiTxEn=1 and gmiiTxEr=1, and the packet ends there with no padding and no check bytes. gmiiTxEr is never high while gmiiTxEn is low.
- R6: If sTvalid is low when a payload byte is due, the packet ends with one transfer of 0x00 with gmiiTxEn=1 and gmiiTxEr=1. The rest of that input packet, up to and including its sTlast beat, is then accepted and produces no output.
- R7: The packets sent immediately before and after an aborted packet (R5, R6) are complete, with correct padding and check bytes.
- R8: When the next packet is already waiting, exactly max(cfgIfg,1) idle byte times, with gmiiTxEn=0, separate the end of a good packet from the first preamble byte of the next.
- R9: While cfgTxEnable is low, no new packet starts and sTready stays low. A packet that has already started finishes.
- R10: With miiSelect=1, each byte, idle bytes included, takes two transfers on gmiiTxd[3:0], low nibble first, with gmiiTxd[7:4]=0. The gap of R8 is counted in byte times.
- R11: Outputs and internal state change only on clock edges where clkEnable is high, and sTready is low whenever clkEnable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sTdata | input | 8 | Input stream byte |
| sTvalid | input | 1 | Input byte valid |
| sTready | output | 1 | Input byte accepted on this edge |
| sTlast | input | 1 | Final byte of the packet |
| sTuser | input | 1 | Packet is bad (taken on the last beat) |
| gmiiTxd | output | 8 | Transmit data (nibble in [3:0] in MII mode) |
| gmiiTxEn | output | 1 | Transmit enable |
| gmiiTxEr | output | 1 | Transmit error |
| cfgIfg | input | 8 | Idle gap in byte times |
| cfgTxEnable | input | 1 | Allows new packets to start |
| miiSelect | input | 1 | 1 selects nibble-wide MII output |
| clkEnable | input | 1 | Qualifies every clock edge |

## Verification
Every output is a register that is loaded on an enabled edge, so a byte appears on gmiiTxd one enabled edge after the decision that produces it. A payload byte accepted on an edge is visible right after that same edge. In MII mode the high nibble follows on the next enabled edge. The bench samples outputs at the falling clock edge and records a transfer only when the preceding rising edge had clkEnable high. Packets and gap lengths are therefore rebuilt in byte times, whatever the enable pattern. The bench drives stimulus half a cycle before the rising edge and reads sTready after that, so acceptance is decided on the coming edge. Expected preamble, payload, padding, check bytes and error placement come from a software CRC model in the bench.

// File: rtl/gmiitx_pkg.sv
`timescale 1ns/1ps
package gmiitx_pkg;
  typedef enum logic [2:0] {SEL_IDLE, SEL_PRE, SEL_SFD, SEL_DATA, SEL_ZERO, SEL_FCS} byteSel_e;

  typedef struct packed {
    byteSel_e sel;
    logic     en;
    logic     er;
    logic     crcInit;
    logic     crcFeed;
    logic     crcShift;
  } txStrobe_t;

  localparam logic [7:0] PRE_BYTE = 8'h55;
  localparam logic [7:0] SFD_BYTE = 8'hD5;
endpackage

// File: rtl/gmiitx_ctrl.sv
`timescale 1ns/1ps
module gmiitx_ctrl
  import gmiitx_pkg::*;
#(
  parameter int MIN_LEN = 60,
  parameter int PRE_LEN = 7,
  parameter int IFG_W   = 8,
  parameter int FCS_LEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             sTvalid,
  input  logic             sTlast,
  input  logic             sTuser,
  input  logic [IFG_W-1:0] cfgIfg,
  input  logic             cfgTxEnable,
  output logic             sTready,
  output txStrobe_t        strobe
);
  localparam int LEN_W  = $clog2(MIN_LEN + 1);
  localparam int PRE_W  = $clog2(PRE_LEN + 1);
  localparam int MAX_LW = (LEN_W > PRE_W) ? LEN_W : PRE_W;
  localparam int CNT_W  = (MAX_LW > IFG_W) ? MAX_LW : IFG_W;
  localparam logic [CNT_W-1:0] MIN_C  = CNT_W'(MIN_LEN);
  localparam logic [CNT_W-1:0] PRE_C  = CNT_W'(PRE_LEN);
  localparam logic [CNT_W-1:0] FCS_C  = CNT_W'(FCS_LEN - 1);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

  typedef enum logic [2:0] {ST_IDLE, ST_PRE, ST_DATA, ST_PAD, ST_FCS, ST_DRAIN, ST_GAP} txState_e;

  txState_e state, nState;
  logic [CNT_W-1:0] cnt, nCnt;
  logic wantReady;

  always_comb begin
    nState    = state;
    nCnt      = cnt;
    strobe    = '0;
    strobe.sel = SEL_IDLE;
    wantReady = 1'b0;
    case (state)
      ST_IDLE: begin
        strobe.crcInit = 1'b1;
        if (cfgTxEnable && sTvalid) begin
          strobe.sel = SEL_PRE;
          strobe.en  = 1'b1;
          nState     = ST_PRE;
          nCnt       = ONE_C;
        end
      end
      ST_PRE: begin
        strobe.en = 1'b1;
        if (cnt == PRE_C) begin
          strobe.sel = SEL_SFD;
          nState     = ST_DATA;
          nCnt       = '0;
        end else begin
          strobe.sel = SEL_PRE;
          nCnt       = cnt + ONE_C;
        end
      end
      ST_DATA: begin
        wantReady = 1'b1;
        strobe.en = 1'b1;
        if (sTvalid) begin
          strobe.sel     = SEL_DATA;
          strobe.crcFeed = 1'b1;
          if (cnt < MIN_C) nCnt = cnt + ONE_C;
          if (sTlast) begin
            if (sTuser) begin
              strobe.er = 1'b1;
              nState    = ST_GAP;
              nCnt      = '0;
            end else if (cnt + ONE_C >= MIN_C) begin
              nState = ST_FCS;
              nCnt   = '0;
            end else begin
              nState = ST_PAD;
            end
          end
        end else begin
          strobe.sel = SEL_ZERO;
          strobe.er  = 1'b1;
          nState     = ST_DRAIN;
        end
      end
      ST_PAD: begin
        strobe.en      = 1'b1;
        strobe.sel     = SEL_ZERO;
        strobe.crcFeed = 1'b1;
        if (cnt + ONE_C >= MIN_C) begin
          nState = ST_FCS;
          nCnt   = '0;
        end else begin
          nCnt = cnt + ONE_C;
        end
      end
      ST_FCS: begin
        strobe.en       = 1'b1;
        strobe.sel      = SEL_FCS;
        strobe.crcShift = 1'b1;
        if (cnt == FCS_C) begin
          nState = ST_GAP;
          nCnt   = '0;
        end else begin
          nCnt = cnt + ONE_C;
        end
      end
      ST_DRAIN: begin
        wantReady = 1'b1;
        if (sTvalid && sTlast) begin
          nState = ST_GAP;
          nCnt   = '0;
        end
      end
      ST_GAP: begin
        if (cnt + ONE_C >= CNT_W'(cfgIfg)) begin
          nState = ST_IDLE;
          nCnt   = '0;
        end else begin
          nCnt = cnt + ONE_C;
        end
      end
      default: nState = ST_IDLE;
    endcase
  end

  assign sTready = wantReady & step;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (step) begin
      state <= nState;
      cnt   <= nCnt;
    end
  end

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !cfgTxEnable) |=> (state == ST_IDLE));

  // R6
  drain_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DRAIN) |-> !strobe.en);
endmodule

// File: rtl/gmiitx_dpath.sv
`timescale 1ns/1ps
module gmiitx_dpath
  import gmiitx_pkg::*;
#(
  parameter logic [31:0] POLY = 32'h04C11DB7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clkEnable,
  input  logic       miiSelect,
  input  logic [7:0] sTdata,
  input  txStrobe_t  strobe,
  output logic       step,
  output logic [7:0] gmiiTxd,
  output logic       gmiiTxEn,
  output logic       gmiiTxEr
);
  function automatic logic [31:0] reflect32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  localparam logic [31:0] POLY_R = reflect32(POLY);

  function automatic logic [31:0] crcByte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] x;
    logic fb;
    x = c;
    for (int i = 0; i < 8; i++) begin
      fb = x[0] ^ d[i];
      x  = {1'b0, x[31:1]} ^ (fb ? POLY_R : 32'h0);
    end
    return x;
  endfunction

  logic        phase;
  logic [3:0]  hiNib;
  logic [31:0] crcReg;
  logic [7:0]  byteNext;

  assign step = clkEnable & (~miiSelect | ~phase);

  always_comb begin
    case (strobe.sel)
      SEL_PRE:  byteNext = PRE_BYTE;
      SEL_SFD:  byteNext = SFD_BYTE;
      SEL_DATA: byteNext = sTdata;
      SEL_FCS:  byteNext = ~crcReg[7:0];
      default:  byteNext = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crcReg <= '1;
    end else if (step) begin
      if (strobe.crcInit)       crcReg <= '1;
      else if (strobe.crcFeed)  crcReg <= crcByte(crcReg, byteNext);
      else if (strobe.crcShift) crcReg <= {8'h00, crcReg[31:8]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= 1'b0;
      hiNib    <= '0;
      gmiiTxd  <= '0;
      gmiiTxEn <= 1'b0;
      gmiiTxEr <= 1'b0;
    end else if (clkEnable) begin
      phase <= miiSelect & ~phase;
      if (step) begin
        gmiiTxEn <= strobe.en;
        gmiiTxEr <= strobe.er;
        hiNib    <= byteNext[7:4];
        gmiiTxd  <= miiSelect ? {4'h0, byteNext[3:0]} : byteNext;
      end else begin
        gmiiTxd <= {4'h0, hiNib};
      end
    end
  end

  // R2
  preamble_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gmiiTxEn) |-> (gmiiTxd == (miiSelect ? 8'h05 : 8'h55)));

  // R5
  err_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    gmiiTxEr |-> gmiiTxEn);

  // R10
  mii_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (miiSelect && gmiiTxEn) |-> (gmiiTxd[7:4] == 4'h0));

  // R11
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !clkEnable |=> ($stable(gmiiTxd) && $stable(gmiiTxEn) && $stable(gmiiTxEr)));
endmodule

// File: rtl/gmii_frame_tx.sv
`timescale 1ns/1ps
module gmii_frame_tx
  import gmiitx_pkg::*;
#(
  parameter int MIN_LEN = 60,
  parameter int PRE_LEN = 7,
  parameter int IFG_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       sTdata,
  input  logic             sTvalid,
  output logic             sTready,
  input  logic             sTlast,
  input  logic             sTuser,
  output logic [7:0]       gmiiTxd,
  output logic             gmiiTxEn,
  output logic             gmiiTxEr,
  input  logic [IFG_W-1:0] cfgIfg,
  input  logic             cfgTxEnable,
  input  logic             miiSelect,
  input  logic             clkEnable
);
  txStrobe_t strobe;
  logic      step;

  gmiitx_ctrl #(.MIN_LEN(MIN_LEN), .PRE_LEN(PRE_LEN), .IFG_W(IFG_W), .FCS_LEN(4)) uCtrl (
    .clk(clk), .rst(rst), .step(step), .sTvalid(sTvalid), .sTlast(sTlast),
    .sTuser(sTuser), .cfgIfg(cfgIfg), .cfgTxEnable(cfgTxEnable),
    .sTready(sTready), .strobe(strobe)
  );

  gmiitx_dpath #(.POLY(32'h04C11DB7)) uDpath (
    .clk(clk), .rst(rst), .clkEnable(clkEnable), .miiSelect(miiSelect),
    .sTdata(sTdata), .strobe(strobe), .step(step),
    .gmiiTxd(gmiiTxd), .gmiiTxEn(gmiiTxEn), .gmiiTxEr(gmiiTxEr)
  );

  // R11
  ready_gated_chk: assert property (@(posedge clk) disable iff (rst)
    sTready |-> clkEnable);
endmodule

// File: tb/tb_gmii_frame_tx.sv
`timescale 1ns/1ps
module tb_gmii_frame_tx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] sTdata = '0;
  logic sTvalid = 1'b0, sTlast = 1'b0, sTuser = 1'b0;
  logic sTready;
  logic [7:0] gmiiTxd;
  logic gmiiTxEn, gmiiTxEr;
  logic [7:0] cfgIfg = 8'd12;
  logic cfgTxEnable = 1'b1, miiSelect = 1'b0, clkEnable = 1'b1;

  gmii_frame_tx dut (
    .clk(clk), .rst(rst), .sTdata(sTdata), .sTvalid(sTvalid), .sTready(sTready),
    .sTlast(sTlast), .sTuser(sTuser), .gmiiTxd(gmiiTxd), .gmiiTxEn(gmiiTxEn),
    .gmiiTxEr(gmiiTxEr), .cfgIfg(cfgIfg), .cfgTxEnable(cfgTxEnable),
    .miiSelect(miiSelect), .clkEnable(clkEnable)
  );

  always #2.5 clk = ~clk;

  int nChecks = 0, nFails = 0;
  int cePeriod = 1, ceCnt = 0;
  logic ceSeen = 1'b1;

  always @(posedge clk) begin
    ceSeen <= clkEnable;
    #1;
    ceCnt++;
    clkEnable = (cePeriod <= 1) || (ceCnt % cePeriod == 0);
  end

  // capture of transmitted packets
  logic [7:0] capBytes [0:7][0:199];
  int  capLen [0:7];
  bit  capErr [0:7];
  int  capGap [0:7];
  int  capCount = 0, curLen = 0, gapSamples = 0, holdBad = 0;
  bit  inFrame = 0, curErr = 0, nib = 0;
  logic [3:0] loNib;
  logic [9:0] lastOut = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!ceSeen && lastOut != {gmiiTxd, gmiiTxEn, gmiiTxEr}) holdBad++;
      if (ceSeen) begin
        if (gmiiTxEn) begin
          if (!inFrame) begin
            inFrame = 1; curLen = 0; curErr = 0; nib = 0;
            if (capCount < 8) capGap[capCount] = miiSelect ? gapSamples / 2 : gapSamples;
          end
          if (gmiiTxEr) curErr = 1;
          if (miiSelect && !nib) begin
            loNib = gmiiTxd[3:0]; nib = 1;
          end else begin
            if (capCount < 8 && curLen < 200)
              capBytes[capCount][curLen] = miiSelect ? {gmiiTxd[3:0], loNib} : gmiiTxd;
            curLen++; nib = 0;
          end
        end else begin
          if (inFrame) begin
            if (capCount < 8) begin
              capLen[capCount] = curLen; capErr[capCount] = curErr;
            end
            capCount++; inFrame = 0; gapSamples = 0;
          end
          gapSamples++;
        end
      end
    end
    lastOut = {gmiiTxd, gmiiTxEn, gmiiTxEr};
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] payByte(input int seed, input int i);
    return 8'(seed + i);
  endfunction

  function automatic logic [31:0] expFcs(input int len, input int seed);
    logic [31:0] c = 32'hFFFFFFFF;
    int tot = (len < 60) ? 60 : len;
    for (int i = 0; i < tot; i++) begin
      c ^= {24'h0, (i < len) ? payByte(seed, i) : 8'h00};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic clearCap();
    @(posedge clk);
    capCount = 0; gapSamples = 0; holdBad = 0;
  endtask

  task automatic sendFrame(input int len, input int seed, input bit bad, input int stallAt);
    int i = 0;
    int stallLeft = (stallAt >= 0) ? 20 : 0;
    while (i < len) begin
      @(negedge clk);
      if (i == stallAt && stallLeft > 0) begin
        sTvalid = 0; stallLeft--;
      end else begin
        sTvalid = 1; sTdata = payByte(seed, i);
        sTlast = (i == len - 1); sTuser = bad && (i == len - 1);
        #1;
        if (sTready) i++;
      end
    end
    @(negedge clk);
    sTvalid = 0; sTlast = 0; sTuser = 0;
  endtask

  task automatic waitFrames(input int n);
    int t = 0;
    while (capCount < n && t < 20000) begin @(negedge clk); t++; end
    repeat (40) @(negedge clk);
  endtask

  task automatic checkGood(input int idx, input int len, input int seed, input string req);
    int tot = (len < 60) ? 60 : len;
    int preBad = 0, datBad = 0, fcsBad = 0;
    logic [31:0] f = expFcs(len, seed);
    chk(capLen[idx] == 8 + tot + 4, req, "packet length", capLen[idx], 8 + tot + 4);
    chk(capErr[idx] == 0, req, "error flag on good packet", capErr[idx], 0);
    for (int i = 0; i < 8; i++)
      if (capBytes[idx][i] != ((i == 7) ? 8'hD5 : 8'h55)) preBad++;
    for (int i = 0; i < tot; i++)
      if (capBytes[idx][8+i] != ((i < len) ? payByte(seed, i) : 8'h00)) datBad++;
    for (int i = 0; i < 4; i++)
      if (capBytes[idx][8+tot+i] != f[8*i +: 8]) fcsBad++;
    chk(preBad == 0, "R2", "preamble mismatches", preBad, 0);
    chk(datBad == 0, (len < 60) ? "R4" : "R2", "payload/pad mismatches", datBad, 0);
    chk(fcsBad == 0, "R3", "check byte mismatches", fcsBad, 0);
  endtask

  task automatic tReset();
    @(negedge clk);
    chk(gmiiTxEn == 0 && gmiiTxEr == 0 && gmiiTxd == 0, "R1", "outputs in reset",
        {gmiiTxd, gmiiTxEn, gmiiTxEr}, 0);
    rst = 0;
    @(negedge clk);
    chk(gmiiTxEn == 0 && gmiiTxEr == 0 && gmiiTxd == 0 && sTready == 0, "R1",
        "outputs after reset", {gmiiTxd, gmiiTxEn, gmiiTxEr, sTready}, 0);
  endtask

  task automatic tBasic();
    clearCap();
    sendFrame(60, 3, 0, -1);
    sendFrame(100, 77, 0, -1);
    waitFrames(2);
    chk(capCount == 2, "R2", "packet count", capCount, 2);
    checkGood(0, 60, 3, "R3");
    checkGood(1, 100, 77, "R3");
    chk(capGap[1] == 12, "R8", "gap with cfgIfg=12", capGap[1], 12);
  endtask

  task automatic tPad();
    clearCap();
    sendFrame(20, 40, 0, -1);
    sendFrame(59, 5, 0, -1);
    waitFrames(2);
    checkGood(0, 20, 40, "R4");
    checkGood(1, 59, 5, "R4");
  endtask

  task automatic tUser();
    clearCap();
    sendFrame(60, 1, 0, -1);
    sendFrame(60, 2, 1, -1);
    sendFrame(60, 3, 0, -1);
    waitFrames(3);
    chk(capCount == 3, "R5", "packet count", capCount, 3);
    checkGood(0, 60, 1, "R7");
    chk(capLen[1] == 68, "R5", "bad packet length", capLen[1], 68);
    chk(capErr[1] == 1, "R5", "bad packet error flag", capErr[1], 1);
    chk(capBytes[1][67] == payByte(2, 59), "R5", "last byte of bad packet",
        capBytes[1][67], payByte(2, 59));
    checkGood(2, 60, 3, "R7");
  endtask

  task automatic tUnderrun();
    clearCap();
    sendFrame(60, 10, 0, -1);
    sendFrame(60, 20, 0, 30);
    sendFrame(60, 30, 0, -1);
    waitFrames(3);
    chk(capCount == 3, "R6", "packet count (drain silent)", capCount, 3);
    checkGood(0, 60, 10, "R7");
    chk(capLen[1] == 39, "R6", "underrun packet length", capLen[1], 39);
    chk(capErr[1] == 1, "R6", "underrun error flag", capErr[1], 1);
    chk(capBytes[1][38] == 8'h00, "R6", "underrun final byte", capBytes[1][38], 0);
    checkGood(2, 60, 30, "R7");
  endtask

  task automatic tGap();
    cfgIfg = 8'd5;
    clearCap();
    sendFrame(60, 8, 0, -1);
    sendFrame(60, 9, 0, -1);
    waitFrames(2);
    chk(capGap[1] == 5, "R8", "gap with cfgIfg=5", capGap[1], 5);
    cfgIfg = 8'd0;
    clearCap();
    sendFrame(60, 8, 0, -1);
    sendFrame(60, 9, 0, -1);
    waitFrames(2);
    chk(capGap[1] == 1, "R8", "gap with cfgIfg=0", capGap[1], 1);
    checkGood(1, 60, 9, "R3");
    cfgIfg = 8'd12;
  endtask

  task automatic tDisable();
    int bad = 0;
    clearCap();
    cfgTxEnable = 0;
    fork sendFrame(60, 50, 0, -1); join_none
    repeat (60) begin
      @(negedge clk); #2;
      if (sTready || gmiiTxEn) bad++;
    end
    chk(bad == 0 && capCount == 0, "R9", "activity while disabled", bad + capCount, 0);
    cfgTxEnable = 1;
    wait fork;
    waitFrames(1);
    checkGood(0, 60, 50, "R9");
  endtask

  task automatic tMii();
    miiSelect = 1;
    repeat (4) @(negedge clk);
    clearCap();
    sendFrame(60, 60, 0, -1);
    sendFrame(25, 61, 0, -1);
    waitFrames(2);
    checkGood(0, 60, 60, "R10");
    checkGood(1, 25, 61, "R10");
    chk(capGap[1] == 12, "R10", "MII gap in byte times", capGap[1], 12);
    miiSelect = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic tCe();
    cePeriod = 3;
    clearCap();
    sendFrame(64, 90, 0, -1);
    waitFrames(1);
    checkGood(0, 64, 90, "R11");
    chk(holdBad == 0, "R11", "output changes on disabled edges", holdBad, 0);
    miiSelect = 1;
    repeat (8) @(negedge clk);
    clearCap();
    sendFrame(60, 91, 0, -1);
    sendFrame(60, 92, 1, -1);
    waitFrames(2);
    checkGood(0, 60, 91, "R11");
    chk(capErr[1] == 1 && capLen[1] == 68, "R11", "bad packet under enable+MII",
        capLen[1], 68);
    chk(holdBad == 0, "R11", "output changes on disabled edges (MII)", holdBad, 0);
    miiSelect = 0;
    cePeriod = 1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 190000);
    nFails++;
    $display("FAIL watchdog: run did not finish actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    tReset();
    repeat (4) @(negedge clk);
    tBasic();
    tPad();
    tUser();
    tUnderrun();
    tGap();
    tDisable();
    tMii();
    tCe();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule